// File: doc/BRIEF.md
# Flash Command Interface State Machine

A synthesizable behavioural model of the command and status logic of a parallel NOR flash device with sector erase. The host drives a chip-select, a write strobe and a read strobe, an 11-bit word address and a 16-bit data word. It programs or erases the small internal array by writing multi-cycle unlock command sequences. Program and erase run as timed embedded operations, and their lengths come from parameterized down-counters. While an operation runs, the block reports status on a ready output and through polled bits on the data output. When the operation finishes, the block goes back to array reads.

The block also supports several other functions. An erase can be suspended and later resumed. While it is suspended, the host may read or program any sector that is not being erased. A bypass mode shortens a program to two bus writes. A lock input marks individual sectors as protected. A low-supply input blocks every bus write. An asynchronous hardware reset aborts any running operation. All strobes are active low and are sampled on the rising clock edge. A bus write is any cycle with chip-select and the write strobe both low. A bus read is any cycle with chip-select and the read strobe low while the write strobe is high. Read data appears on `dout` after the clock edge that samples the read.

Top module: `flash_cmd`

## Requirements
- R1: After hardware reset, `ready` is 1 and a read returns the stored word. An erased word reads FFFFh.
- R2: A program runs only after four writes in this order: AAh at address 555h, 55h at 2AAh, A0h at 555h, then the data at the target word. Command bytes are compared on `din[7:0]`. `ready` then stays 0 for exactly PROG_CYC cycles.
- R3: A program ANDs its data into the stored word, so it can clear bits but never set them.
- R4: While `ready` is 0, a read returns the complement of data bit 7 of the running program on bit 7. For an erase, bit 7 reads 0. Bit 6 inverts on every such read, and all other bits read 0. Once `ready` is 1 again, reads return array data.
- R5: A write with the wrong value or the wrong address in any unlock cycle sends the decoder back to array read. No data and no mode changes.
- R6: A sector erase is AAh/555h, 55h/2AAh, 80h/555h, AAh/555h, 55h/2AAh, then 30h at any address inside the target sector. Sectors are address bits [5:4]. A chip erase ends instead with 10h at 555h. The chosen unprotected sectors are first cleared to 0000h and then, ERASE_CYC busy cycles later, read FFFFh. Every other sector keeps its data.
- R7: A write of B0h during an erase suspends it. `ready` returns to 1, the erase counter holds, and array reads work. Programs to sectors outside the erase complete normally, and programs to sectors inside it are ignored. A write of 30h while suspended and idle resumes the erase, which finishes after the cycles it had left.
- R8: The code 20h, in place of A0h in the program sequence, enters bypass mode. In bypass mode a program takes two writes: A0h, then the data. The writes 90h then 00h leave bypass mode, after which the two-write program is ignored.
- R9: A program or erase aimed at a sector whose `sector_lock` bit is 1 is ignored. `ready` stays 1 and the data is unchanged.
- R10: Driving `rst_n` low aborts a running program or erase, leaves bypass and suspend, and returns the decoder to array read. The target word of an aborted program is unchanged.
- R11: While `low_vdd` is 1, every bus write is ignored.
- R12: A write of F0h in the middle of a command sequence returns the decoder to array read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Read strobe, active low |
| addr | input | AW | Word address |
| din | input | 16 | Write data and command byte |
| dout | output | 16 | Read data or status |
| ready | output | 1 | 1 when no program or unsuspended erase is running |
| sector_lock | input | SECTORS | Per-sector protection, 1 = protected |
| low_vdd | input | 1 | Low-supply indication; blocks writes |

## Verification
The bench suspends an erase a known number of cycles after it starts, then counts the busy cycles left after resume. A counter that kept running while suspended, or that reloaded on resume, gives the wrong count. It sends an unlock sequence broken by a wrong byte or a wrong address, then a complete program sequence. A decoder that did not fall back to idle would program the word. It also programs inside the sector being erased while the erase is suspended, programs after leaving bypass mode, and programs a word to which 1 bits are written over 0 bits. Each of these shows up as a changed word that should have kept its old value.

// File: rtl/flash_cmd.sv
module flash_cmd #(
  parameter int AW        = 11,
  parameter int DEPTH     = 64,
  parameter int SECTORS   = 4,
  parameter int PROG_CYC  = 6,
  parameter int ERASE_CYC = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ce_n,
  input  logic               we_n,
  input  logic               oe_n,
  input  logic [AW-1:0]      addr,
  input  logic [15:0]        din,
  output logic [15:0]        dout,
  output logic               ready,
  input  logic [SECTORS-1:0] sector_lock,
  input  logic               low_vdd
);
  localparam int IW   = $clog2(DEPTH);
  localparam int SW   = $clog2(SECTORS);
  localparam int SECW = DEPTH / SECTORS;
  localparam int MAXC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  typedef enum logic [2:0] {
    CS_IDLE, CS_U1, CS_U2, CS_PDATA, CS_E1, CS_E2, CS_E3, CS_BX
  } cs_t;

  logic [15:0]        mem [DEPTH] = '{default: 16'hFFFF};
  cs_t                cs;
  logic               bypass, tog;
  logic               pgm_on, ers_on, ers_susp;
  logic [CW-1:0]      pgm_cnt, ers_cnt;
  logic [IW-1:0]      pgm_addr;
  logic [15:0]        pgm_data;
  logic [SECTORS-1:0] ers_sel, new_sel, fill_sel;

  wire [7:0]    cmd   = din[7:0];
  wire          wr    = !ce_n && !we_n && !low_vdd;
  wire          rd    = !ce_n && !oe_n && we_n;
  wire          busy  = pgm_on || (ers_on && !ers_susp);
  wire          at555 = addr[10:0] == 11'h555;
  wire          at2aa = addr[10:0] == 11'h2AA;
  wire [IW-1:0] idx   = addr[IW-1:0];
  wire [SW-1:0] sec   = idx[IW-1 -: SW];
  wire          tgt7  = pgm_on ? pgm_data[7] : 1'b1;
  wire          pgm_ok   = !sector_lock[sec] && !(ers_on && ers_sel[sec]);
  wire          pgm_done = pgm_on && pgm_cnt == '0;
  wire          ers_done = ers_on && !ers_susp && ers_cnt == '0;
  wire          e3_hit   = rst_n && wr && !busy && !ers_on && cs == CS_E3;

  always_comb begin
    new_sel = '0;
    if (e3_hit && cmd == 8'h10 && at555)
      new_sel = ~sector_lock;
    else if (e3_hit && cmd == 8'h30)
      new_sel = (SECTORS'(1) << sec) & ~sector_lock;
  end

  wire ers_start = |new_sel;
  assign fill_sel = ers_done ? ers_sel : new_sel;
  assign ready    = !busy;

  always_ff @(posedge clk) begin
    if (pgm_done)
      mem[pgm_addr] <= mem[pgm_addr] & pgm_data;
    if (ers_start || ers_done)
      for (int i = 0; i < DEPTH; i++)
        if (fill_sel[SW'(i / SECW)])
          mem[IW'(i)] <= ers_done ? 16'hFFFF : 16'h0000;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs       <= CS_IDLE;
      bypass   <= 1'b0;
      tog      <= 1'b0;
      dout     <= '0;
      pgm_on   <= 1'b0;
      ers_on   <= 1'b0;
      ers_susp <= 1'b0;
      pgm_cnt  <= '0;
      ers_cnt  <= '0;
      pgm_addr <= '0;
      pgm_data <= '0;
      ers_sel  <= '0;
    end else begin
      if (rd) begin
        dout <= busy ? {8'h00, ~tgt7, tog, 6'h00} : mem[idx];
        if (busy) tog <= ~tog;
      end

      if (pgm_on) begin
        if (pgm_cnt == '0) pgm_on <= 1'b0;
        else pgm_cnt <= pgm_cnt - 1'b1;
      end
      if (ers_on && !ers_susp) begin
        if (ers_cnt == '0) ers_on <= 1'b0;
        else ers_cnt <= ers_cnt - 1'b1;
      end

      if (wr && busy) begin
        if (cmd == 8'hB0 && ers_on && !pgm_on) ers_susp <= 1'b1;
      end else if (wr) begin
        if (cmd == 8'hF0 && cs != CS_PDATA) begin
          cs <= CS_IDLE;
        end else begin
          case (cs)
            CS_IDLE: begin
              if (cmd == 8'h30 && ers_susp) ers_susp <= 1'b0;
              else if (bypass && cmd == 8'hA0) cs <= CS_PDATA;
              else if (bypass && cmd == 8'h90) cs <= CS_BX;
              else if (!bypass && cmd == 8'hAA && at555) cs <= CS_U1;
            end
            CS_U1: cs <= (cmd == 8'h55 && at2aa) ? CS_U2 : CS_IDLE;
            CS_U2: begin
              cs <= CS_IDLE;
              if (cmd == 8'hA0 && at555) cs <= CS_PDATA;
              else if (cmd == 8'h80 && at555 && !ers_on) cs <= CS_E1;
              else if (cmd == 8'h20 && at555) bypass <= 1'b1;
            end
            CS_PDATA: begin
              cs <= CS_IDLE;
              if (pgm_ok) begin
                pgm_on   <= 1'b1;
                pgm_addr <= idx;
                pgm_data <= din;
                pgm_cnt  <= CW'(PROG_CYC - 1);
              end
            end
            CS_E1: cs <= (cmd == 8'hAA && at555) ? CS_E2 : CS_IDLE;
            CS_E2: cs <= (cmd == 8'h55 && at2aa) ? CS_E3 : CS_IDLE;
            CS_E3: begin
              cs <= CS_IDLE;
              if (ers_start) begin
                ers_on  <= 1'b1;
                ers_sel <= new_sel;
                ers_cnt <= CW'(ERASE_CYC - 1);
              end
            end
            CS_BX: begin
              cs <= CS_IDLE;
              if (cmd == 8'h00) bypass <= 1'b0;
            end
            default: cs <= CS_IDLE;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/flash_cmd_chk.sv
module flash_cmd_chk #(
  parameter int IW      = 6,
  parameter int SW      = 2,
  parameter int SECTORS = 4,
  parameter int CW      = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ce_n,
  input logic               we_n,
  input logic               oe_n,
  input logic               low_vdd,
  input logic               ready,
  input logic [15:0]        dout,
  input logic [SECTORS-1:0] sector_lock,
  input logic               pgm_on,
  input logic [IW-1:0]      pgm_addr,
  input logic               ers_susp,
  input logic [CW-1:0]      ers_cnt
);
  wire          rd      = !ce_n && !oe_n && we_n;
  wire [SW-1:0] pgm_sec = pgm_addr[IW-1 -: SW];
  logic [SECTORS-1:0] lock_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) lock_q <= '0;
    else lock_q <= sector_lock;

  assert_status_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !ready) |=> (dout[15:8] == 8'h00 && dout[5:0] == 6'h00));

  assert_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !ready) ##1 (rd && !ready) |=> dout[6] != $past(dout[6]));

  assert_no_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (low_vdd && ready) |=> ready);

  assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> ready);

  assert_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pgm_on) |-> !lock_q[pgm_sec]);

  assert_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ers_susp && $past(ers_susp)) |-> $stable(ers_cnt));
endmodule

bind flash_cmd flash_cmd_chk #(.IW(IW), .SW(SW), .SECTORS(SECTORS), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
  .low_vdd(low_vdd), .ready(ready), .dout(dout), .sector_lock(sector_lock),
  .pgm_on(pgm_on), .pgm_addr(pgm_addr), .ers_susp(ers_susp), .ers_cnt(ers_cnt)
);

// File: tb/flash_cmd_test.sv
module flash_cmd_test;
  localparam int PC = 6;
  localparam int EC = 20;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [10:0] addr = '0;
  logic [15:0] din = '0;
  logic [15:0] dout;
  logic        ready;
  logic [3:0]  lock = 4'b0000;
  logic        low_vdd = 1'b0;
  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  flash_cmd #(.PROG_CYC(PC), .ERASE_CYC(EC)) uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .dout(dout), .ready(ready),
    .sector_lock(lock), .low_vdd(low_vdd));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [10:0] a, input logic [15:0] d);
    addr = a; din = d; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic rd(input logic [10:0] a, output logic [15:0] d);
    addr = a; ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk);
    d = dout; ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic unlock();
    wr(11'h555, 16'h00AA);
    wr(11'h2AA, 16'h0055);
  endtask

  task automatic prog4(input logic [10:0] a, input logic [15:0] d);
    unlock();
    wr(11'h555, 16'h00A0);
    wr(a, d);
  endtask

  task automatic erase_seq(input logic [10:0] a, input logic [7:0] last);
    unlock();
    wr(11'h555, 16'h0080);
    unlock();
    wr(a, {8'h00, last});
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!ready && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic expect_word(input string req, input logic [10:0] a, input logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic t_reset();
    chk("R1 ready after reset", 16'(ready), 16'd1);
    expect_word("R1 erased word", 11'h003, 16'hFFFF);
  endtask

  task automatic t_program();
    int n;
    prog4(11'h003, 16'h1234);
    chk("R2 busy after 4th write", 16'(ready), 16'd0);
    wait_ready(n);
    chk("R2 program busy length", 16'(n), 16'(PC));
    expect_word("R2 programmed word", 11'h003, 16'h1234);
    prog4(11'h003, 16'hFF00);
    wait_ready(n);
    expect_word("R3 bits only clear", 11'h003, 16'h1200);
  endtask

  task automatic t_poll();
    int n;
    logic [15:0] s1, s2;
    prog4(11'h005, 16'h0080);
    rd(11'h005, s1);
    rd(11'h005, s2);
    chk("R4 status bit7 complement", 16'(s1[7]), 16'd0);
    chk("R4 status other bits", s1 & 16'hFFBF, 16'h0000);
    chk("R4 toggle bit flips", 16'(s2[6] ^ s1[6]), 16'd1);
    wait_ready(n);
    expect_word("R4 true data after done", 11'h005, 16'h0080);
  endtask

  task automatic t_bad_unlock();
    wr(11'h555, 16'h00AA);
    wr(11'h2AA, 16'h0056);
    wr(11'h555, 16'h00A0);
    wr(11'h007, 16'h0000);
    chk("R5 bad data no busy", 16'(ready), 16'd1);
    expect_word("R5 bad data no program", 11'h007, 16'hFFFF);
    wr(11'h554, 16'h00AA);
    wr(11'h2AA, 16'h0055);
    wr(11'h555, 16'h00A0);
    wr(11'h007, 16'h0000);
    expect_word("R5 bad address no program", 11'h007, 16'hFFFF);
  endtask

  task automatic t_f0();
    unlock();
    wr(11'h555, 16'h00F0);
    wr(11'h555, 16'h00A0);
    wr(11'h008, 16'h0000);
    chk("R12 no busy after F0", 16'(ready), 16'd1);
    expect_word("R12 F0 cancels sequence", 11'h008, 16'hFFFF);
  endtask

  task automatic t_protect();
    int n;
    prog4(11'h031, 16'h5555);
    wait_ready(n);
    lock = 4'b1000;
    prog4(11'h032, 16'h0000);
    chk("R9 locked program no busy", 16'(ready), 16'd1);
    expect_word("R9 locked program ignored", 11'h032, 16'hFFFF);
    erase_seq(11'h030, 8'h30);
    chk("R9 locked erase no busy", 16'(ready), 16'd1);
    expect_word("R9 locked erase ignored", 11'h031, 16'h5555);
  endtask

  task automatic t_sector_erase();
    int n;
    prog4(11'h012, 16'hABCD);
    wait_ready(n);
    erase_seq(11'h000, 8'h30);
    chk("R6 erase busy", 16'(ready), 16'd0);
    wait_ready(n);
    chk("R6 erase busy length", 16'(n), 16'(EC));
    expect_word("R6 erased word a", 11'h003, 16'hFFFF);
    expect_word("R6 erased word b", 11'h005, 16'hFFFF);
    expect_word("R6 other sector kept", 11'h012, 16'hABCD);
  endtask

  task automatic t_suspend();
    int n;
    prog4(11'h003, 16'h1111);
    wait_ready(n);
    erase_seq(11'h000, 8'h30);
    @(negedge clk);
    @(negedge clk);
    wr(11'h000, 16'h00B0);
    chk("R7 ready while suspended", 16'(ready), 16'd1);
    expect_word("R7 read other sector", 11'h012, 16'hABCD);
    expect_word("R7 preprogrammed to zero", 11'h003, 16'h0000);
    prog4(11'h013, 16'h00FF);
    chk("R7 program in suspend busy", 16'(ready), 16'd0);
    wait_ready(n);
    chk("R7 program in suspend length", 16'(n), 16'(PC));
    expect_word("R7 program in suspend", 11'h013, 16'h00FF);
    prog4(11'h004, 16'h0000);
    chk("R7 program in erasing sector ignored", 16'(ready), 16'd1);
    wr(11'h000, 16'h0030);
    chk("R7 busy after resume", 16'(ready), 16'd0);
    wait_ready(n);
    chk("R7 remaining erase cycles", 16'(n), 16'(EC - 3));
    expect_word("R7 erase completed", 11'h003, 16'hFFFF);
    expect_word("R7 erase completed b", 11'h004, 16'hFFFF);
    expect_word("R7 suspended program kept", 11'h013, 16'h00FF);
  endtask

  task automatic t_chip_erase();
    int n;
    erase_seq(11'h555, 8'h10);
    wait_ready(n);
    chk("R6 chip erase length", 16'(n), 16'(EC));
    expect_word("R6 chip erase clears", 11'h012, 16'hFFFF);
    expect_word("R6 chip erase skips locked", 11'h031, 16'h5555);
  endtask

  task automatic t_bypass();
    int n;
    unlock();
    wr(11'h555, 16'h0020);
    wr(11'h000, 16'h00A0);
    wr(11'h021, 16'h1357);
    chk("R8 bypass program busy", 16'(ready), 16'd0);
    wait_ready(n);
    chk("R8 bypass program length", 16'(n), 16'(PC));
    expect_word("R8 bypass programmed", 11'h021, 16'h1357);
    wr(11'h000, 16'h0090);
    wr(11'h000, 16'h0000);
    wr(11'h000, 16'h00A0);
    wr(11'h022, 16'h0000);
    chk("R8 exit no busy", 16'(ready), 16'd1);
    expect_word("R8 two-write ignored after exit", 11'h022, 16'hFFFF);
  endtask

  task automatic t_low_vdd();
    low_vdd = 1'b1;
    prog4(11'h023, 16'h0000);
    chk("R11 no busy under low supply", 16'(ready), 16'd1);
    low_vdd = 1'b0;
    expect_word("R11 write inhibited", 11'h023, 16'hFFFF);
  endtask

  task automatic t_hw_reset();
    prog4(11'h024, 16'h0000);
    chk("R10 busy before abort", 16'(ready), 16'd0);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk("R10 ready after abort", 16'(ready), 16'd1);
    expect_word("R10 aborted word unchanged", 11'h024, 16'hFFFF);
    unlock();
    wr(11'h555, 16'h0020);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    wr(11'h000, 16'h00A0);
    wr(11'h025, 16'h0000);
    chk("R10 bypass left", 16'(ready), 16'd1);
    expect_word("R10 bypass program ignored", 11'h025, 16'hFFFF);
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_program();
    t_poll();
    t_bad_unlock();
    t_f0();
    t_protect();
    t_sector_erase();
    t_suspend();
    t_chip_erase();
    t_bypass();
    t_low_vdd();
    t_hw_reset();
    report();
  end
endmodule